// File: doc/BRIEF.md
# PCM Codec Serial Frame Interface

This block is the digital serial port of a telephony PCM codec. On the transmit side, an encoder hands over an 8-bit code with a one-cycle strobe. The block keeps that code in a holding register. At the next transmit frame sync it launches the code MSB first on a serial data pin, driving the pin only during the 8 bit periods of the time slot. On the receive side, a receive frame sync opens a slot. The block samples 8 serial bits on the falling edges of the receive bit clock and presents the assembled byte to a decoder with a one-cycle valid strobe.

Everything runs from the transmit master clock. Both bit clocks and both frame syncs are treated as levels synchronous to that clock, and the block finds their edges itself. Slot timing is keyed only to the frame syncs, so a frame of 193 bit clocks, as used with a 1.544 MHz master clock, costs nothing.

The block also watches the receive master-clock pin. When that pin is held at a static level, it flags that receive master-clock functions must be fed from the transmit master clock instead. When the pin toggles regularly again, it returns the selection. A frame sync that lands in the middle of a slot restarts that slot and raises a sticky error flag.

Top module: `pcm_serial_port`

## Requirements
- R1: While reset is low, and on the first cycle after it, `tx_data_oe`, `tx_data`, `enc_start`, `rx_code_valid` and `frame_error` are 0, `rx_code` is 0x00 and `rx_mclk_fallback` is 1.
- R2: A code presented with `enc_done` is held. It goes out only in the slot opened by the next transmit frame sync. Bit 7 appears one cycle after the `tx_bclk` rising edge at which `tx_fsync` is first seen high, and each later rising edge moves one bit lower.
- R3: `tx_data_oe` is high for exactly 8 transmit bit periods per slot, and `tx_data` is 0 whenever `tx_data_oe` is 0.
- R4: If `enc_done` falls in the same cycle as a slot start, the slot sends the code held before that cycle. The new code goes out one frame later.
- R5: `enc_start` is a one-cycle pulse in the cycle after each transmit slot start.
- R6: After a receive slot start, `rx_data` is sampled on the next 8 falling edges of `rx_bclk`, MSB first. One cycle after the 8th falling edge, `rx_code` carries the byte and `rx_code_valid` is high for one cycle. `rx_code` changes at no other time.
- R7: A frame sync that arrives while its slot is still shifting restarts the slot: on transmit at bit 7 with the currently held code, on receive with a fresh byte. It also sets `frame_error`, which stays 1 until reset.
- R8: Frames of 192 and 193 bit clocks both keep correct slot alignment and leave `frame_error` at 0.
- R9: `rx_mclk_fallback` rises after 16 consecutive `tx_mclk` cycles with no edge on `rx_mclk_pin`, where edges are counted after a 2-stage synchronizer.
- R10: `rx_mclk_fallback` falls after 4 edges on `rx_mclk_pin`, each arriving before 16 edge-free cycles. A 16-cycle gap discards the edges counted so far.
- R11: A frame sync held high for several bit clocks opens only one slot, because a slot starts only on a sync seen low at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_mclk | input | 1 | Transmit master clock; the only clock of the block |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_bclk | input | 1 | Transmit bit clock level |
| tx_fsync | input | 1 | Transmit frame sync level |
| enc_done | input | 1 | Encoder strobe: `enc_code` is valid |
| enc_code | input | 8 | Code from the encoder |
| tx_data | output | 1 | Serial transmit data |
| tx_data_oe | output | 1 | High while `tx_data` should be driven |
| enc_start | output | 1 | Pulse marking the start of an encoding cycle |
| rx_bclk | input | 1 | Receive bit clock level |
| rx_fsync | input | 1 | Receive frame sync level |
| rx_data | input | 1 | Serial receive data |
| rx_code | output | 8 | Last received code for the decoder |
| rx_code_valid | output | 1 | One-cycle strobe: decode may start |
| rx_mclk_pin | input | 1 | Receive master-clock pin, watched for activity |
| rx_mclk_fallback | output | 1 | 1 when receive master-clock functions use `tx_mclk` |
| frame_error | output | 1 | Sticky: a frame sync cut a slot short |

## Verification
The encoder can hand over a new code in the very cycle in which a transmit frame sync opens a slot. The bench provokes this by raising `enc_done` in the cycle of the sync-qualified bit-clock rising edge. It then judges the serial bits of that slot, which must carry the previously held code, and of the following slot, which must carry the new one. A second meeting point is a frame sync during an active slot, which both restarts the shift and sets the error flag. Both are compared cycle by cycle against a behavioural model, and the captured bytes are checked against constants worked out from the requirements.

// File: rtl/pcm_port_pkg.sv
// Shared constants and types for the PCM serial frame interface.
package pcm_port_pkg;
    localparam int unsigned CODE_BITS = 8;
    typedef logic [CODE_BITS-1:0] code_t;
    // Which master clock receive functions should follow.
    typedef enum logic {SRC_OWN = 1'b0, SRC_TX = 1'b1} rclk_src_e;
endpackage

// File: rtl/pcm_tx_slot.sv
// Transmit slot engine: holds the encoder code and shifts it out MSB first
// in the slot opened by the next frame sync.
// Assumes bclk and fsync are levels synchronous to clk, each bit period
// spanning at least two clk cycles.
module pcm_tx_slot #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bclk,
    input  logic         fsync,
    input  logic         load,
    input  logic [W-1:0] code_in,
    output logic         sdata,
    output logic         sdata_oe,
    output logic         slot_start,
    output logic         restart
);
    localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic          bclk_q;
    logic          fs_seen_q;
    logic          rise;
    logic          start;
    logic [W-1:0]  hold_q;
    logic [W-1:0]  shreg_q;
    logic [CW-1:0] cnt_q;
    logic          act_q;
    logic          start_q;

    assign rise    = bclk & ~bclk_q;
    assign start   = rise & fsync & ~fs_seen_q;
    assign restart = start & act_q & (cnt_q != LAST);

    // Purpose: remember last bit clock level and the sync seen at last rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q    <= 1'b0;
            fs_seen_q <= 1'b0;
        end else begin
            bclk_q <= bclk;
            if (rise) fs_seen_q <= fsync;
        end
    end

    // Purpose: holding buffer for the code produced by the encoder.
    always_ff @(posedge clk) begin
        if (!rst_n)    hold_q <= '0;
        else if (load) hold_q <= code_in;
    end

    // Purpose: slot shifter, launched from the holding buffer at each start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            cnt_q   <= '0;
            act_q   <= 1'b0;
        end else if (start) begin
            shreg_q <= hold_q;
            cnt_q   <= '0;
            act_q   <= 1'b1;
        end else if (rise && act_q) begin
            if (cnt_q == LAST) begin
                act_q <= 1'b0;
            end else begin
                shreg_q <= {shreg_q[W-2:0], 1'b0};
                cnt_q   <= cnt_q + 1'b1;
            end
        end
    end

    // Purpose: one-cycle encode-start pulse after each slot start.
    always_ff @(posedge clk) begin
        if (!rst_n) start_q <= 1'b0;
        else        start_q <= start;
    end

    assign slot_start = start_q;
    assign sdata_oe   = act_q;
    assign sdata      = act_q & shreg_q[W-1];
endmodule

// File: rtl/pcm_rx_slot.sv
// Receive slot engine: after a frame sync, samples W bits on falling bit
// clock edges, MSB first, and presents the byte with a one-cycle strobe.
// Assumes bclk, fsync and sdata are synchronous to clk.
module pcm_rx_slot #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bclk,
    input  logic         fsync,
    input  logic         sdata,
    output logic [W-1:0] code_out,
    output logic         code_valid,
    output logic         restart
);
    localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic          bclk_q;
    logic          fs_seen_q;
    logic          rise;
    logic          fall;
    logic          start;
    logic [W-1:0]  acc_q;
    logic [CW-1:0] cnt_q;
    logic          act_q;
    logic [W-1:0]  code_q;
    logic          valid_q;

    assign rise    = bclk & ~bclk_q;
    assign fall    = ~bclk & bclk_q;
    assign start   = rise & fsync & ~fs_seen_q;
    assign restart = start & act_q;

    // Purpose: remember bit clock level and the sync seen at last rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q    <= 1'b0;
            fs_seen_q <= 1'b0;
        end else begin
            bclk_q <= bclk;
            if (rise) fs_seen_q <= fsync;
        end
    end

    // Purpose: assemble bits on falling edges and publish the full byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            cnt_q   <= '0;
            act_q   <= 1'b0;
            code_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (start) begin
                acc_q <= '0;
                cnt_q <= '0;
                act_q <= 1'b1;
            end else if (fall && act_q) begin
                acc_q <= {acc_q[W-2:0], sdata};
                if (cnt_q == LAST) begin
                    act_q   <= 1'b0;
                    code_q  <= {acc_q[W-2:0], sdata};
                    valid_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign code_out   = code_q;
    assign code_valid = valid_q;
endmodule

// File: rtl/pcm_rxclk_sel.sv
// Receive master-clock source selector: watches a pin for activity and
// requests the transmit master clock when the pin is static.
// Assumes the pin may be asynchronous; it passes a synchronizer first.
module pcm_rxclk_sel
    import pcm_port_pkg::*;
#(
    parameter int unsigned STATIC_CYC  = 16,
    parameter int unsigned GOOD_EDGES  = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mclk_pin,
    output logic use_tx_clk
);
    localparam int unsigned IW = $clog2(STATIC_CYC + 1);
    localparam int unsigned GW = (GOOD_EDGES > 1) ? $clog2(GOOD_EDGES + 1) : 1;

    logic [SYNC_STAGES:0] sync_q;
    logic                 toggled;
    logic [IW-1:0]        idle_q;
    logic [GW-1:0]        good_q;
    rclk_src_e            src_q;

    // Purpose: synchronizer chain plus one stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-1:0], mclk_pin};
    end

    assign toggled = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];

    // Purpose: count cycles since the last pin edge, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                        idle_q <= '0;
        else if (toggled)                  idle_q <= '0;
        else if (idle_q != IW'(STATIC_CYC)) idle_q <= idle_q + 1'b1;
    end

    // Purpose: switch source on a static pin, return after enough edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= SRC_TX;
            good_q <= '0;
        end else if (!toggled && idle_q == IW'(STATIC_CYC - 1)) begin
            src_q  <= SRC_TX;
            good_q <= '0;
        end else if (src_q == SRC_TX && toggled) begin
            if (good_q == GW'(GOOD_EDGES - 1)) begin
                src_q  <= SRC_OWN;
                good_q <= '0;
            end else begin
                good_q <= good_q + 1'b1;
            end
        end
    end

    assign use_tx_clk = (src_q == SRC_TX);
endmodule

// File: rtl/pcm_serial_port.sv
// PCM codec serial frame interface top: transmit slot, receive slot,
// receive clock selection and the sticky frame error flag.
// Assumes all inputs except rx_mclk_pin are synchronous to tx_mclk.
module pcm_serial_port
    import pcm_port_pkg::*;
#(
    parameter int unsigned STATIC_CYC  = 16,
    parameter int unsigned GOOD_EDGES  = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 tx_mclk,
    input  logic                 rst_n,
    input  logic                 tx_bclk,
    input  logic                 tx_fsync,
    input  logic                 enc_done,
    input  logic [CODE_BITS-1:0] enc_code,
    output logic                 tx_data,
    output logic                 tx_data_oe,
    output logic                 enc_start,
    input  logic                 rx_bclk,
    input  logic                 rx_fsync,
    input  logic                 rx_data,
    output logic [CODE_BITS-1:0] rx_code,
    output logic                 rx_code_valid,
    input  logic                 rx_mclk_pin,
    output logic                 rx_mclk_fallback,
    output logic                 frame_error
);
    logic tx_restart;
    logic rx_restart;
    logic err_q;

    pcm_tx_slot #(.W(CODE_BITS)) tx_i (
        .clk        (tx_mclk),
        .rst_n      (rst_n),
        .bclk       (tx_bclk),
        .fsync      (tx_fsync),
        .load       (enc_done),
        .code_in    (enc_code),
        .sdata      (tx_data),
        .sdata_oe   (tx_data_oe),
        .slot_start (enc_start),
        .restart    (tx_restart)
    );

    pcm_rx_slot #(.W(CODE_BITS)) rx_i (
        .clk        (tx_mclk),
        .rst_n      (rst_n),
        .bclk       (rx_bclk),
        .fsync      (rx_fsync),
        .sdata      (rx_data),
        .code_out   (rx_code),
        .code_valid (rx_code_valid),
        .restart    (rx_restart)
    );

    pcm_rxclk_sel #(
        .STATIC_CYC  (STATIC_CYC),
        .GOOD_EDGES  (GOOD_EDGES),
        .SYNC_STAGES (SYNC_STAGES)
    ) sel_i (
        .clk        (tx_mclk),
        .rst_n      (rst_n),
        .mclk_pin   (rx_mclk_pin),
        .use_tx_clk (rx_mclk_fallback)
    );

    // Purpose: sticky record of any slot cut short by a frame sync.
    always_ff @(posedge tx_mclk) begin
        if (!rst_n)                       err_q <= 1'b0;
        else if (tx_restart || rx_restart) err_q <= 1'b1;
    end

    assign frame_error = err_q;
endmodule

// File: rtl/pcm_serial_port_chk.sv
// Property checker for pcm_serial_port, attached by bind.
module pcm_serial_port_chk (
    input logic       tx_mclk,
    input logic       rst_n,
    input logic       tx_data,
    input logic       tx_data_oe,
    input logic       enc_start,
    input logic [7:0] rx_code,
    input logic       rx_code_valid,
    input logic       rx_mclk_pin,
    input logic       rx_mclk_fallback,
    input logic       frame_error
);
    // R3
    tx_quiet_chk: assert property (@(posedge tx_mclk) disable iff (!rst_n)
        !tx_data_oe |-> !tx_data);

    // R5
    enc_pulse_chk: assert property (@(posedge tx_mclk) disable iff (!rst_n)
        enc_start |=> !enc_start);

    // R6
    rx_valid_pulse_chk: assert property (@(posedge tx_mclk) disable iff (!rst_n)
        rx_code_valid |=> !rx_code_valid);

    // R6
    rx_code_hold_chk: assert property (@(posedge tx_mclk) disable iff (!rst_n)
        (rx_code != $past(rx_code)) |-> rx_code_valid);

    // R7
    err_sticky_chk: assert property (@(posedge tx_mclk) disable iff (!rst_n)
        frame_error |=> frame_error);

    // R9
    fallback_quiet_chk: assert property (@(posedge tx_mclk) disable iff (!rst_n)
        $rose(rx_mclk_fallback) |-> $stable(rx_mclk_pin));
endmodule

bind pcm_serial_port pcm_serial_port_chk chk_i (
    .tx_mclk          (tx_mclk),
    .rst_n            (rst_n),
    .tx_data          (tx_data),
    .tx_data_oe       (tx_data_oe),
    .enc_start        (enc_start),
    .rx_code          (rx_code),
    .rx_code_valid    (rx_code_valid),
    .rx_mclk_pin      (rx_mclk_pin),
    .rx_mclk_fallback (rx_mclk_fallback),
    .frame_error      (frame_error)
);

// File: tb/pcm_serial_port_tb.sv
module pcm_serial_port_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 60000;

    logic       tx_mclk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_bclk = 1'b0, tx_fsync = 1'b0, enc_done = 1'b0;
    logic [7:0] enc_code = 8'h00;
    logic       rx_bclk = 1'b0, rx_fsync = 1'b0, rx_data = 1'b0;
    logic       rx_mclk_pin = 1'b0;
    logic       tx_data, tx_data_oe, enc_start, rx_code_valid;
    logic       rx_mclk_fallback, frame_error;
    logic [7:0] rx_code;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit cmp_en = 0;
    bit done = 0;

    pcm_serial_port dut_i (
        .tx_mclk(tx_mclk), .rst_n(rst_n), .tx_bclk(tx_bclk), .tx_fsync(tx_fsync),
        .enc_done(enc_done), .enc_code(enc_code), .tx_data(tx_data),
        .tx_data_oe(tx_data_oe), .enc_start(enc_start), .rx_bclk(rx_bclk),
        .rx_fsync(rx_fsync), .rx_data(rx_data), .rx_code(rx_code),
        .rx_code_valid(rx_code_valid), .rx_mclk_pin(rx_mclk_pin),
        .rx_mclk_fallback(rx_mclk_fallback), .frame_error(frame_error)
    );

    always #(CLK_PERIOD/2) tx_mclk = ~tx_mclk;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int         m_idx;
    logic [7:0] m_word, m_hold, m_code;
    bit         m_bx, m_fx, m_br, m_fr, m_ract, m_valid, m_err, m_fb, m_es;
    bit         m_rbits[$];
    bit         m_pins[$];
    int         m_quiet, m_good;

    always @(posedge tx_mclk) begin
        if (!rst_n) begin
            m_idx = -1; m_word = 0; m_hold = 0; m_code = 0;
            m_bx = 0; m_fx = 0; m_br = 0; m_fr = 0; m_ract = 0;
            m_valid = 0; m_err = 0; m_fb = 1; m_es = 0;
            m_rbits.delete(); m_pins = '{0, 0, 0, 0};
            m_quiet = 0; m_good = 0;
        end else begin
            bit trise, tstart, rrise, rfall, rstart, pedge;
            trise  = tx_bclk && !m_bx;
            tstart = trise && tx_fsync && !m_fx;
            if (trise) m_fx = tx_fsync;
            m_bx = tx_bclk;
            m_es = tstart;
            if (tstart) begin
                if (m_idx > 0) m_err = 1;
                m_word = m_hold;
                m_idx = 7;
            end else if (trise && m_idx >= 0) begin
                m_idx--;
            end
            if (enc_done) m_hold = enc_code;

            rrise  = rx_bclk && !m_br;
            rfall  = !rx_bclk && m_br;
            rstart = rrise && rx_fsync && !m_fr;
            if (rrise) m_fr = rx_fsync;
            m_br = rx_bclk;
            m_valid = 0;
            if (rstart) begin
                if (m_ract) m_err = 1;
                m_ract = 1;
                m_rbits.delete();
            end else if (rfall && m_ract) begin
                m_rbits.push_back(rx_data);
                if (m_rbits.size() == 8) begin
                    for (int i = 0; i < 8; i++) m_code[7-i] = m_rbits[i];
                    m_valid = 1;
                    m_ract = 0;
                end
            end

            m_pins.push_front(rx_mclk_pin);
            pedge = (m_pins[2] != m_pins[3]);
            void'(m_pins.pop_back());
            if (pedge) begin
                m_quiet = 0;
                if (m_fb) begin
                    m_good++;
                    if (m_good == 4) begin m_fb = 0; m_good = 0; end
                end
            end else begin
                m_quiet++;
                if (m_quiet == 16) begin m_fb = 1; m_good = 0; end
            end
        end
    end

    // Cycle-by-cycle comparison away from the active edge.
    int valid_cnt = 0;
    always @(negedge tx_mclk) begin
        if (cmp_en && rst_n) begin
            chk("R3", "tx_data_oe", tx_data_oe, (m_idx >= 0));
            chk("R2", "tx_data", tx_data, (m_idx >= 0) ? m_word[m_idx] : 1'b0);
            chk("R5", "enc_start", enc_start, m_es);
            chk("R6", "rx_code_valid", rx_code_valid, m_valid);
            chk("R6", "rx_code", rx_code, m_code);
            chk("R7", "frame_error", frame_error, m_err);
            chk("R9", "rx_mclk_fallback", rx_mclk_fallback, m_fb);
            if (rx_code_valid) valid_cnt++;
        end
    end

    // Receive master-clock pin generator: toggles every rm_half cycles, 0 = static.
    int rm_half = 3;
    int rm_cnt = 0;
    always @(negedge tx_mclk) begin
        if (rm_half > 0) begin
            if (rm_cnt >= rm_half - 1) begin
                rx_mclk_pin = ~rx_mclk_pin;
                rm_cnt = 0;
            end else begin
                rm_cnt++;
            end
        end
    end

    // Watchdog.
    always @(posedge tx_mclk) begin
        cyc++;
        if (cyc > WATCHDOG && !done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog R1-chain actual=%0d expected=<%0d", cyc, WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    bit capq[$];

    task automatic bitp(input logic fx, input logic fr, input logic d,
                        input logic en, input logic [7:0] c);
        @(negedge tx_mclk);
        tx_bclk = 1; rx_bclk = 1; tx_fsync = fx; rx_fsync = fr;
        enc_done = en; enc_code = c;
        @(negedge tx_mclk);
        enc_done = 0;
        if (tx_data_oe) capq.push_back(tx_data);
        @(negedge tx_mclk);
        tx_bclk = 0; rx_bclk = 0; rx_data = d;
        @(negedge tx_mclk);
    endtask

    task automatic frame(input int nb, input int fslen, input logic [7:0] rxb,
                         input int enc_at, input logic [7:0] c);
        capq.delete();
        for (int b = 0; b < nb; b++)
            bitp(b < fslen, b < fslen, (b < 8) ? rxb[7-b] : 1'b0, b == enc_at, c);
    endtask

    task automatic chk_tx(input string req, input logic [7:0] exp);
        logic [7:0] got;
        got = 0;
        chk(req, "tx slot length", capq.size(), 8);
        for (int i = 0; i < capq.size() && i < 8; i++) got[7-i] = capq[i];
        chk(req, "tx byte", got, exp);
    endtask

    task automatic reset_checks();
        chk("R1", "tx_data_oe", tx_data_oe, 0);
        chk("R1", "tx_data", tx_data, 0);
        chk("R1", "enc_start", enc_start, 0);
        chk("R1", "rx_code_valid", rx_code_valid, 0);
        chk("R1", "rx_code", rx_code, 8'h00);
        chk("R1", "frame_error", frame_error, 0);
        chk("R1", "rx_mclk_fallback", rx_mclk_fallback, 1);
    endtask

    initial begin
        repeat (4) @(negedge tx_mclk);
        reset_checks();
        rst_n = 1;
        cmp_en = 1;
        @(negedge tx_mclk);
        reset_checks();

        // R2: first slot sends the reset hold value, code A5 captured later
        frame(16, 1, 8'h3C, 3, 8'hA5);
        chk_tx("R2", 8'h00);
        chk("R6", "rx byte F1", rx_code, 8'h3C);
        chk("R10", "fallback cleared by running pin", rx_mclk_fallback, 0);
        // R4: new code 5A in the start cycle, slot still sends A5
        frame(16, 1, 8'hC5, 0, 8'h5A);
        chk_tx("R4", 8'hA5);
        chk("R6", "rx byte F2", rx_code, 8'hC5);
        // R8: 193-clock frame, then 192-clock frame
        frame(193, 1, 8'h96, 10, 8'hC3);
        chk_tx("R4", 8'h5A);
        chk("R8", "no error after 193", frame_error, 0);
        frame(192, 1, 8'h69, 20, 8'h81);
        chk_tx("R8", 8'hC3);
        chk("R8", "rx byte after 193 frame", rx_code, 8'h69);
        // R11: sync held high for 3 bit clocks
        frame(16, 3, 8'hF0, -1, 8'h00);
        chk_tx("R11", 8'h81);
        chk("R11", "rx byte", rx_code, 8'hF0);
        chk("R11", "valid count", valid_cnt, 5);
        chk("R11", "no error", frame_error, 0);
        // R7: slot cut short after 4 bits
        frame(4, 1, 8'hAA, -1, 8'h00);
        frame(16, 1, 8'h55, -1, 8'h00);
        chk_tx("R7", 8'h81);
        chk("R7", "rx byte after restart", rx_code, 8'h55);
        chk("R7", "error set", frame_error, 1);
        frame(4, 0, 8'h00, -1, 8'h00);
        chk("R7", "error sticky", frame_error, 1);
        cmp_en = 0;
        rst_n = 0;
        repeat (3) @(negedge tx_mclk);
        chk("R7", "error cleared by reset", frame_error, 0);
        rst_n = 1;
        @(negedge tx_mclk);
        cmp_en = 1;
        repeat (30) @(negedge tx_mclk);
        chk("R10", "fallback cleared again", rx_mclk_fallback, 0);

        // R9: static pin
        rm_half = 0;
        repeat (40) @(negedge tx_mclk);
        chk("R9", "fallback on static pin", rx_mclk_fallback, 1);
        // R10: edges too far apart never return
        rm_half = 20;
        repeat (200) @(negedge tx_mclk);
        chk("R10", "slow edges keep fallback", rx_mclk_fallback, 1);
        // R10: regular edges return
        rm_half = 5;
        repeat (60) @(negedge tx_mclk);
        chk("R10", "fast edges release fallback", rx_mclk_fallback, 0);
        rm_half = 0;
        repeat (12) @(negedge tx_mclk);
        chk("R9", "not yet static", rx_mclk_fallback, 0);
        repeat (20) @(negedge tx_mclk);
        chk("R9", "static again", rx_mclk_fallback, 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule